// File: doc/BRIEF.md
# Escaped Serial Frame Decoder

This block sits behind a byte-wide serial receiver. It recovers framed packets from the incoming byte stream. It looks for the start marker 0x7E and drops anything before it. It then collects a big-endian length field and passes the payload bytes out one per beat on a valid/ready port. After the payload it judges the trailing checksum byte. When the escaped mode is selected, byte stuffing is removed before any byte is counted or summed.

Each output beat carries one byte and four flags: first beat of a frame, closing beat of a frame, checksum error and resynchronisation. A payload byte travels on its own beat. The checksum byte comes last, on a closing beat that carries the verdict on the checksum. If a frame in escaped mode is cut short by a fresh start marker, the block emits a closing beat that flags both an error and a resynchronisation. It then starts collecting the new frame at once.

Top module: `esc_frame_decoder`

## Requirements
- R1: During and directly after reset, out_valid is 0 and in_ready is 1.
- R2: While no frame is open, every byte other than 0x7E is dropped and produces no beat.
- R3: A 0x7E opens a frame. The next two decoded bytes form the length, most significant byte first. Exactly that many payload beats follow, in arrival order, with out_sof set only on the first beat of the frame.
- R4: With esc_mode=1, the byte 0x7D is removed and the byte after it is XORed with 0x20. This restoration applies to the length bytes, the payload and the checksum alike.
- R5: With esc_mode=0, 0x7D is passed through as ordinary data. Inside an open frame, 0x7E is also ordinary data.
- R6: The byte after the payload yields one closing beat with out_eof=1 and out_data equal to the decoded checksum byte. On that beat out_ck_err=1 exactly when the 8-bit sum of the payload bytes and the checksum byte differs from 0xFF. out_ck_err is never set without out_eof.
- R7: A frame of length zero yields a single beat with both out_sof and out_eof set.
- R8: With esc_mode=1, a 0x7E that arrives while a frame is open yields a closing beat with out_data=0x00, out_eof=1, out_ck_err=1 and out_resync=1. It also opens a new frame.
- R9: With esc_mode=1, an escape byte directly followed by 0x7E inside a frame is treated as malformed. It yields the R8 closing beat (error and resync set), and the 0x7E still opens the next frame.
- R10: While out_valid=1 and out_ready=0, in_ready is 0 and the offered beat stays unchanged.
- R11: A byte that produces a beat shows up on the outputs after the same clock edge that accepts it. A cycle with no accepted byte and no held beat leaves out_valid at 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esc_mode | input | 1 | 1 selects escaped mode, 0 unescaped |
| in_valid | input | 1 | A received byte is offered |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | The block takes the offered byte at this edge |
| out_valid | output | 1 | A beat is offered |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 8 | Payload byte, checksum byte, or 0x00 on an abort beat |
| out_sof | output | 1 | First beat of a frame |
| out_eof | output | 1 | Closing beat of a frame |
| out_ck_err | output | 1 | Checksum wrong or frame malformed (closing beat only) |
| out_resync | output | 1 | Frame cut short by a new start marker |

## Verification
A beat is loaded at the same rising edge that accepts the byte causing it. So a payload, closing or abort beat is due one edge after acceptance, and a held beat stays put for as long as out_ready stays low. The bench drives bytes and sets out_ready just after a rising edge. It reads beats at the falling edge and compares them in order against a queue filled by a reference model, which is updated only at the edge where a byte is accepted. The directed latency and stall checks sample one time unit after the accepting edge, and after several falling edges of a stall.

// File: rtl/esc_frame_pkg.sv
package esc_frame_pkg;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_LEN  = 2'd1,
      ST_BODY = 2'd2,
      ST_CSUM = 2'd3
   } fr_state_e;

   typedef struct packed {
      logic       resync;
      logic       ck_err;
      logic       eof;
      logic       sof;
      logic [7:0] data;
   } beat_t;

   localparam logic [7:0] SUM_GOOD = 8'hFF;

endpackage

// File: rtl/esc_unstuff.sv
module esc_unstuff #(
   parameter int         DATA_W = 8,
   parameter bit         ESC_EN = 1'b1,
   parameter logic [7:0] DELIM  = 8'h7E,
   parameter logic [7:0] ESC    = 8'h7D,
   parameter logic [7:0] FLIP   = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic [DATA_W-1:0] raw,
   input  logic              esc_mode,
   output logic              esc_on,
   output logic              dv,
   output logic [DATA_W-1:0] db,
   output logic              delim_hit
);

   if (DATA_W != 8) begin : g_bad_width
      $error("esc_unstuff: byte stuffing is defined on 8-bit symbols");
   end

   if (ESC_EN) begin : g_esc
      logic pend;
      logic is_delim;
      logic is_esc;

      assign is_delim = (raw == DELIM);
      assign is_esc   = (raw == ESC);
      assign esc_on   = esc_mode;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend <= 1'b0;
         end else if (!esc_mode) begin
            pend <= 1'b0;
         end else if (acc) begin
            pend <= is_esc && !pend;
         end
      end

      assign delim_hit = acc && esc_mode && is_delim;
      assign dv        = acc && !(esc_mode && (is_delim || (is_esc && !pend)));
      assign db        = (esc_mode && pend) ? (raw ^ FLIP) : raw;
   end else begin : g_plain
      assign esc_on    = 1'b0;
      assign delim_hit = 1'b0;
      assign dv        = acc;
      assign db        = raw;
   end

endmodule

// File: rtl/frame_tracker.sv
module frame_tracker
   import esc_frame_pkg::*;
#(
   parameter int         DATA_W = 8,
   parameter int         LEN_W  = 16,
   parameter logic [7:0] DELIM  = 8'h7E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic [DATA_W-1:0] raw,
   input  logic              esc_on,
   input  logic              dv,
   input  logic [DATA_W-1:0] db,
   input  logic              delim_hit,
   output logic              emit,
   output beat_t             beat
);

   localparam int LEN_BYTES = LEN_W / 8;
   localparam int IDX_W     = (LEN_BYTES > 1) ? $clog2(LEN_BYTES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN_BYTES - 1);

   if ((LEN_W % 8) != 0 || LEN_W < 8) begin : g_bad_len
      $error("frame_tracker: LEN_W must be a whole number of bytes");
   end

   fr_state_e        st, st_n;
   logic [LEN_W-1:0] len_acc, len_acc_n;
   logic [LEN_W-1:0] rem, rem_n;
   logic [IDX_W-1:0] idx, idx_n;
   logic [7:0]       sum, sum_n;
   logic             first, first_n;
   logic             delim_ev;
   logic             data_ev;
   logic [LEN_W+7:0] len_cat;
   logic [LEN_W-1:0] len_shift;
   logic [7:0]       sum_tot;

   assign delim_ev  = esc_on ? delim_hit : (acc && (st == ST_HUNT) && (raw == DELIM));
   assign data_ev   = dv && !delim_ev;
   assign len_cat   = {len_acc, db};
   assign len_shift = len_cat[LEN_W-1:0];
   assign sum_tot   = sum + db;

   always_comb begin
      st_n      = st;
      len_acc_n = len_acc;
      rem_n     = rem;
      idx_n     = idx;
      sum_n     = sum;
      first_n   = first;
      emit      = 1'b0;
      beat      = '0;
      if (delim_ev) begin
         if (st != ST_HUNT) begin
            emit        = 1'b1;
            beat.resync = 1'b1;
            beat.ck_err = 1'b1;
            beat.eof    = 1'b1;
            beat.sof    = first;
         end
         st_n      = ST_LEN;
         len_acc_n = '0;
         idx_n     = '0;
         sum_n     = '0;
         first_n   = 1'b1;
      end else if (data_ev) begin
         unique case (st)
            ST_HUNT: begin
               st_n = ST_HUNT;
            end
            ST_LEN: begin
               len_acc_n = len_shift;
               if (idx == LAST_IDX) begin
                  rem_n = len_shift;
                  st_n  = (len_shift == '0) ? ST_CSUM : ST_BODY;
               end else begin
                  idx_n = idx + IDX_W'(1);
               end
            end
            ST_BODY: begin
               emit      = 1'b1;
               beat.data = db;
               beat.sof  = first;
               first_n   = 1'b0;
               sum_n     = sum_tot;
               rem_n     = rem - LEN_W'(1);
               if (rem == LEN_W'(1)) begin
                  st_n = ST_CSUM;
               end
            end
            ST_CSUM: begin
               emit        = 1'b1;
               beat.data   = db;
               beat.sof    = first;
               beat.eof    = 1'b1;
               beat.ck_err = (sum_tot != SUM_GOOD);
               first_n     = 1'b0;
               st_n        = ST_HUNT;
            end
            default: st_n = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_HUNT;
         len_acc <= '0;
         rem     <= '0;
         idx     <= '0;
         sum     <= '0;
         first   <= 1'b0;
      end else begin
         st      <= st_n;
         len_acc <= len_acc_n;
         rem     <= rem_n;
         idx     <= idx_n;
         sum     <= sum_n;
         first   <= first_n;
      end
   end

endmodule

// File: rtl/beat_reg.sv
module beat_reg
   import esc_frame_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  beat_t beat_in,
   input  logic  out_ready,
   output logic  out_valid,
   output beat_t beat_q,
   output logic  free
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         beat_q    <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         beat_q    <= beat_in;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assign free = !out_valid || out_ready;

endmodule

// File: rtl/esc_frame_decoder.sv
module esc_frame_decoder
   import esc_frame_pkg::*;
#(
   parameter int         DATA_W = 8,
   parameter int         LEN_W  = 16,
   parameter bit         ESC_EN = 1'b1,
   parameter logic [7:0] DELIM  = 8'h7E,
   parameter logic [7:0] ESC    = 8'h7D,
   parameter logic [7:0] FLIP   = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              esc_mode,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_ck_err,
   output logic              out_resync
);

   if (DATA_W != 8) begin : g_bad_width
      $error("esc_frame_decoder: DATA_W must be 8");
   end

   logic              acc;
   logic              esc_on;
   logic              dv;
   logic [DATA_W-1:0] db;
   logic              delim_hit;
   logic              emit;
   beat_t             beat_n;
   beat_t             beat_q;
   logic              free;

   assign acc      = in_valid && free;
   assign in_ready = free;

   esc_unstuff #(
      .DATA_W (DATA_W),
      .ESC_EN (ESC_EN),
      .DELIM  (DELIM),
      .ESC    (ESC),
      .FLIP   (FLIP)
   ) u_unstuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .raw       (in_data),
      .esc_mode  (esc_mode),
      .esc_on    (esc_on),
      .dv        (dv),
      .db        (db),
      .delim_hit (delim_hit)
   );

   frame_tracker #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W),
      .DELIM  (DELIM)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .raw       (in_data),
      .esc_on    (esc_on),
      .dv        (dv),
      .db        (db),
      .delim_hit (delim_hit),
      .emit      (emit),
      .beat      (beat_n)
   );

   beat_reg u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (acc && emit),
      .beat_in   (beat_n),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .beat_q    (beat_q),
      .free      (free)
   );

   assign out_data   = beat_q.data;
   assign out_sof    = beat_q.sof;
   assign out_eof    = beat_q.eof;
   assign out_ck_err = beat_q.ck_err;
   assign out_resync = beat_q.resync;

endmodule

// File: rtl/esc_frame_decoder_chk.sv
module esc_frame_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_eof,
   input logic       out_ck_err,
   input logic       out_resync
);

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof))) // R10
      else $error("held beat changed");

   AST_ERR_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ck_err) |-> out_eof) // R6
      else $error("error flag outside closing beat");

   AST_RESYNC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_resync) |-> (out_eof && out_ck_err && (out_data == 8'h00))) // R8
      else $error("abort beat malformed");

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(in_valid && in_ready) && !(out_valid && !out_ready)) |=> !out_valid) // R11
      else $error("beat without a byte");

endmodule

bind esc_frame_decoder esc_frame_decoder_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .out_eof    (out_eof),
   .out_ck_err (out_ck_err),
   .out_resync (out_resync)
);

// File: tb/esc_frame_decoder_bench.sv
module esc_frame_decoder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       esc_mode = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_data;
   logic       out_sof, out_eof, out_ck_err, out_resync;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int rdy_mode = 0;

   logic [11:0] exp_q[$];
   string       tag_q[$];
   string       cur_tag = "R1";

   // reference model state
   int         m_st = 0;          // 0 hunt, 1 len, 2 body, 3 csum
   bit         m_pend = 1'b0;
   bit         m_first = 1'b0;
   int         m_idx = 0;
   int         m_len = 0;
   int         m_rem = 0;
   logic [7:0] m_sum = 8'h00;

   always #2 clk = ~clk;

   esc_frame_decoder u_esc_frame_decoder (
      .clk(clk), .rst_n(rst_n), .esc_mode(esc_mode),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sof(out_sof), .out_eof(out_eof), .out_ck_err(out_ck_err),
      .out_resync(out_resync)
   );

   always @(posedge clk) begin
      #1;
      if (rdy_mode == 0) out_ready = 1'b1;
      else if (rdy_mode == 2) out_ready = 1'b0;
      else out_ready = (($urandom % 10) < 7);
   end

   task automatic push_exp(input logic [11:0] e);
      exp_q.push_back(e);
      tag_q.push_back(cur_tag);
   endtask

   task automatic model_byte(input logic [7:0] b_in);
      logic [7:0] b;
      b = b_in;
      if (esc_mode) begin
         if (b == 8'h7E) begin
            if (m_st != 0) push_exp({1'b1, 1'b1, 1'b1, m_first, 8'h00});
            m_st = 1; m_idx = 0; m_len = 0; m_sum = 8'h00; m_first = 1'b1; m_pend = 1'b0;
            return;
         end
         if (b == 8'h7D && !m_pend) begin
            m_pend = 1'b1;
            return;
         end
         if (m_pend) begin
            b = b ^ 8'h20;
            m_pend = 1'b0;
         end
      end else begin
         m_pend = 1'b0;
         if (m_st == 0 && b == 8'h7E) begin
            m_st = 1; m_idx = 0; m_len = 0; m_sum = 8'h00; m_first = 1'b1;
            return;
         end
      end
      case (m_st)
         1: begin
            m_len = (m_len * 256 + int'(b)) % 65536;
            if (m_idx == 1) begin
               m_rem = m_len;
               m_st = (m_len == 0) ? 3 : 2;
            end else m_idx++;
         end
         2: begin
            push_exp({1'b0, 1'b0, 1'b0, m_first, b});
            m_first = 1'b0;
            m_sum = m_sum + b;
            m_rem--;
            if (m_rem == 0) m_st = 3;
         end
         3: begin
            push_exp({1'b0, ((m_sum + b) != 8'hFF), 1'b1, m_first, b});
            m_first = 1'b0;
            m_st = 0;
         end
         default: ;
      endcase
   endtask

   task automatic put(input logic [7:0] b);
      bit taken;
      taken = 1'b0;
      @(negedge clk);
      in_valid = 1'b1;
      in_data = b;
      while (!taken) begin
         #1;
         if (in_ready) begin
            @(posedge clk);
            taken = 1'b1;
         end else begin
            @(negedge clk);
         end
      end
      model_byte(b);
      #1 in_valid = 1'b0;
   endtask

   task automatic put_esc(input logic [7:0] b);
      if (esc_mode && (b == 8'h7E || b == 8'h7D || b == 8'h11 || b == 8'h13)) begin
         put(8'h7D);
         put(b ^ 8'h20);
      end else put(b);
   endtask

   task automatic send_frame(input logic [7:0] pl[$], input bit corrupt);
      logic [7:0]  s;
      logic [15:0] n;
      s = 8'h00;
      n = 16'(pl.size());
      put(8'h7E);
      put_esc(n[15:8]);
      put_esc(n[7:0]);
      foreach (pl[i]) begin
         put_esc(pl[i]);
         s = s + pl[i];
      end
      s = 8'hFF - s;
      if (corrupt) s = s ^ 8'h5A;
      put_esc(s);
   endtask

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic drain();
      rdy_mode = 0;
      repeat (8) @(negedge clk);
      check(exp_q.size() == 0, {cur_tag, " missing beats"}, 16'(exp_q.size()), 16'd0);
   endtask

   task automatic random_frames(input int count);
      for (int f = 0; f < count; f++) begin
         logic [7:0] pl[$];
         int n;
         int g;
         g = $urandom % 3;
         for (int k = 0; k < g; k++) put(8'($urandom % 8'h7D));
         n = ($urandom % 8 == 0) ? 0 : 1 + ($urandom % 10);
         for (int k = 0; k < n; k++) begin
            if ($urandom % 4 == 0) begin
               case ($urandom % 4)
                  0: pl.push_back(8'h7E);
                  1: pl.push_back(8'h7D);
                  2: pl.push_back(8'h11);
                  default: pl.push_back(8'h13);
               endcase
            end else pl.push_back(8'($urandom));
         end
         send_frame(pl, ($urandom % 5) == 0);
      end
   endtask

   // beat monitor
   logic [11:0] got, want;
   string       wtag;
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         got = {out_resync, out_ck_err, out_eof, out_sof, out_data};
         if (exp_q.size() == 0) begin
            check(1'b0, {cur_tag, " unexpected beat"}, 16'(got), 16'hFFFF);
         end else begin
            want = exp_q.pop_front();
            wtag = tag_q.pop_front();
            check(got === want, {wtag, " beat {resync,err,eof,sof,data}"}, 16'(got), 16'(want));
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] pl[$];
      int unused_seed;
      unused_seed = $urandom(32'd4711);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(!out_valid && in_ready, "R1 reset state", {14'd0, out_valid, in_ready}, 16'h0001);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && in_ready, "R1 after reset", {14'd0, out_valid, in_ready}, 16'h0001);

      // R11 latency
      cur_tag = "R11";
      put(8'h7E); put(8'h00); put(8'h01);
      check(!out_valid, "R11 no beat for length", {15'd0, out_valid}, 16'd0);
      put(8'h5A);
      check(out_valid && out_sof && out_data == 8'h5A, "R11 beat after accept edge",
            {6'd0, out_valid, out_sof, out_data}, {6'd0, 2'b11, 8'h5A});
      put(8'hA5);
      drain();

      // R10 stall
      cur_tag = "R10";
      rdy_mode = 2;
      put(8'h7E); put(8'h00); put(8'h02); put(8'hA1);
      repeat (3) @(negedge clk);
      check(out_valid && !in_ready && out_data == 8'hA1, "R10 held beat",
            {6'd0, out_valid, in_ready, out_data}, {6'd0, 2'b10, 8'hA1});
      rdy_mode = 0;
      put(8'hA2); put(8'hBC);
      drain();

      // R2 garbage before frame
      cur_tag = "R2";
      put(8'h01); put(8'h55); put(8'h7C);
      repeat (2) @(negedge clk);
      check(!out_valid, "R2 garbage dropped", {15'd0, out_valid}, 16'd0);
      pl = '{8'h33};
      send_frame(pl, 1'b0);
      drain();

      // R4 escaped length/payload/checksum
      cur_tag = "R4";
      pl = '{8'h11, 8'hAA, 8'h7E, 8'h7D, 8'h13};
      send_frame(pl, 1'b0);
      put(8'h7E); put(8'h00); put(8'h7D); put(8'h33);   // escaped length 0x13
      for (int k = 0; k < 19; k++) put(8'h00);
      put(8'hFF);
      drain();

      // R6 bad checksum
      cur_tag = "R6";
      pl = '{8'h01, 8'h02, 8'h03};
      send_frame(pl, 1'b1);
      drain();

      // R7 zero length
      cur_tag = "R7";
      put(8'h7E); put(8'h00); put(8'h00); put(8'hFF);
      drain();

      // R8 mid-frame delimiter
      cur_tag = "R8";
      put(8'h7E); put(8'h00); put(8'h05); put(8'h01); put(8'h02);
      pl = '{8'h44, 8'h45};
      send_frame(pl, 1'b0);
      put(8'h7E); put(8'h00);
      put(8'h7E); put(8'h00); put(8'h00); put(8'hFF);
      drain();

      // R9 escape right before delimiter
      cur_tag = "R9";
      put(8'h7E); put(8'h00); put(8'h02); put(8'h01); put(8'h7D);
      pl = '{8'h66};
      send_frame(pl, 1'b0);
      drain();

      // R3 random escaped traffic with backpressure
      cur_tag = "R3";
      rdy_mode = 1;
      random_frames(60);
      drain();

      // R5 unescaped mode
      esc_mode = 1'b0;
      cur_tag = "R5";
      put(8'h7E); put(8'h00); put(8'h03); put(8'h7D); put(8'h7E); put(8'h11); put(8'hF3);
      drain();
      rdy_mode = 1;
      random_frames(60);
      drain();

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule